// File: doc/BRIEF.md
# Seeded Pseudorandom Burst Pattern Generator and Checker

This block sits beside a memory test sequencer. It supplies write data for burst accesses from a pseudorandom sequence and checks the returned read data against the same sequence, regenerated on the read side. Two copies of one 32-bit maximal-length Galois LFSR run from the same seed. One feeds the write path and moves on each write beat. The other supplies expected read data and moves only on each valid read beat, so read latency has no effect on alignment.

The sequencer controls the seed in three ways. A test start loads a base seed. A phase start reloads both generators from the current seed, so every phase of a test sees the same data. A repetition step adds a fixed odd constant to the seed, so each repetition of a test gets fresh data. The whole word can be inverted. In phase mode the inversion is a flag captured at each (re)load. In row mode the inversion is a per-beat bit for each path. Each compared beat raises a mismatch flag on any difference and ORs the differing bits into a sticky error mask. Only a test start clears that mask.

Top module: `prp_engine`

## Requirements
- R1: After reset, err_mask and mismatch are 0, the seed register is 0, the phase inversion flag is 0, and both generators hold DEFAULT_SEED (32'hACE1_2468).
- R2: A start cycle loads the seed register with base_seed, loads both generators with that seed, captures phase_inv and clears err_mask and mismatch at the next edge.
- R3: The generator step is s' = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 0). Data word bits [31:0] are the current state and bits [63:32] are one step later. Each write beat (wr_adv) moves the write generator two steps.
- R4: A phase_start cycle reloads both generators from the current seed and captures phase_inv, so every phase repeats the same data.
- R5: rep_next adds SEED_STEP (32'h9E37_79B9) to the seed register. When rep_next and phase_start occur in the same cycle, the reload uses the incremented seed.
- R6: Any seed equal to zero is loaded into the generators as DEFAULT_SEED, so neither generator state is ever zero.
- R7: The compare generator moves two steps only on rd_valid, independently of wr_adv.
- R8: With inv_by_row = 0, both paths invert the whole word when the captured phase flag is 1. With inv_by_row = 1, wr_row_inv inverts wr_data and rd_row_inv inverts the expected read word.
- R9: One cycle after a compared read beat, mismatch is 1 exactly when rd_data differs from the expected word. In every other cycle mismatch is 0.
- R10: err_mask ORs in the XOR difference of every compared beat and holds it until the next start.
- R11: start has priority over phase_start, and both have priority over rep_next, wr_adv and rd_valid. A read beat in a start or phase_start cycle is not compared and does not advance a generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test: load base seed, clear error mask |
| phase_start | input | 1 | Reload both generators from the current seed |
| rep_next | input | 1 | Step the seed to the next repetition |
| base_seed | input | 32 | Seed used at test start |
| phase_inv | input | 1 | Phase inversion flag, captured at a (re)load |
| inv_by_row | input | 1 | 1 selects per-beat row inversion, 0 selects phase inversion |
| wr_adv | input | 1 | Write beat consumed, advance the write generator |
| wr_row_inv | input | 1 | Row inversion for the current write beat |
| wr_data | output | DATA_W | Write data word |
| rd_valid | input | 1 | Read beat valid |
| rd_row_inv | input | 1 | Row inversion for the current read beat |
| rd_data | input | DATA_W | Returned read data |
| mismatch | output | 1 | Registered: last compared beat differed |
| err_mask | output | DATA_W | Sticky OR of bit differences |

## Verification
The assertions check on every cycle that err_mask never loses a bit except at a start and is zero right after one. They also check that mismatch only follows a compared read beat and always comes with a nonzero mask, that neither generator state is ever zero, and that the compare generator holds still without a read beat. Only the bench scenarios can show that the data values are right. This covers the polynomial and word packing, the same data repeating across phases, the different data produced by a repetition step, the replacement of a zero seed, inversion in both modes, and the priority of the load controls. The bench checks these against its own model of the sequence, using random and directed traffic.

// File: rtl/prp_pkg.sv
package prp_pkg;
  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;
  localparam logic [LFSR_W-1:0] DEF_SEED = 32'hACE1_2468;
  localparam logic [LFSR_W-1:0] DEF_STEP = 32'h9E37_79B9;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    lfsr_step = (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s,
                                                 input logic [LFSR_W-1:0] dflt);
    seed_fix = (s == '0) ? dflt : s;
  endfunction
endpackage

// File: rtl/prp_seed_ctrl.sv
module prp_seed_ctrl
  import prp_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED_STEP    = DEF_STEP,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              phase_start,
  input  logic              rep_next,
  input  logic [LFSR_W-1:0] base_seed,
  input  logic              phase_inv,
  output logic              load,
  output logic [LFSR_W-1:0] load_seed,
  output logic              phase_inv_q
);
  logic [LFSR_W-1:0] seed_q, seed_nxt;
  logic              pinv_nxt;

  always_comb begin
    seed_nxt = seed_q;
    if (start)         seed_nxt = base_seed;
    else if (rep_next) seed_nxt = seed_q + SEED_STEP;
  end

  assign load      = start | phase_start;
  assign load_seed = seed_fix(seed_nxt, DEFAULT_SEED);
  assign pinv_nxt  = load ? phase_inv : phase_inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q      <= '0;
      phase_inv_q <= 1'b0;
    end else begin
      seed_q      <= seed_nxt;
      phase_inv_q <= pinv_nxt;
    end
  end
endmodule

// File: rtl/prp_lfsr_gen.sv
module prp_lfsr_gen
  import prp_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] load_seed,
  input  logic              adv,
  output logic [LFSR_W-1:0] state,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned NST    = (DATA_W + LFSR_W - 1) / LFSR_W;
  localparam int unsigned FULL_W = NST * LFSR_W;

  logic [LFSR_W-1:0] chain [NST+1];
  logic [FULL_W-1:0] word_full;
  logic [LFSR_W-1:0] state_nxt;

  assign chain[0] = state;
  for (genvar k = 0; k < NST; k++) begin : g_chain
    assign chain[k+1] = lfsr_step(chain[k]);
    assign word_full[k*LFSR_W +: LFSR_W] = chain[k];
  end
  assign word = word_full[DATA_W-1:0];

  always_comb begin
    state_nxt = state;
    if (load)     state_nxt = load_seed;
    else if (adv) state_nxt = chain[NST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= DEFAULT_SEED;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/prp_compare.sv
module prp_compare #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] expected,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mismatch,
  output logic [DATA_W-1:0] err_mask
);
  logic [DATA_W-1:0] diff, mask_nxt;
  logic              mis_nxt;

  assign diff = rd_data ^ expected;

  always_comb begin
    mis_nxt  = cmp_en & (|diff);
    mask_nxt = err_mask;
    if (clear)       mask_nxt = '0;
    else if (cmp_en) mask_nxt = err_mask | diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mismatch <= 1'b0;
      err_mask <= '0;
    end else begin
      mismatch <= mis_nxt;
      err_mask <= mask_nxt;
    end
  end
endmodule

// File: rtl/prp_engine.sv
module prp_engine
  import prp_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter logic [31:0] SEED_STEP    = DEF_STEP,
  parameter logic [31:0] DEFAULT_SEED = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              phase_start,
  input  logic              rep_next,
  input  logic [31:0]       base_seed,
  input  logic              phase_inv,
  input  logic              inv_by_row,
  input  logic              wr_adv,
  input  logic              wr_row_inv,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic              rd_row_inv,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mismatch,
  output logic [DATA_W-1:0] err_mask
);
  logic              load, phase_inv_q, wr_inv, cmp_inv, cmp_en;
  logic [31:0]       load_seed, wr_state, cmp_state;
  logic [DATA_W-1:0] wr_word, cmp_word, expected;

  prp_seed_ctrl #(.SEED_STEP(SEED_STEP), .DEFAULT_SEED(DEFAULT_SEED)) u_seed (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_start(phase_start),
    .rep_next(rep_next), .base_seed(base_seed), .phase_inv(phase_inv),
    .load(load), .load_seed(load_seed), .phase_inv_q(phase_inv_q)
  );

  prp_lfsr_gen #(.DATA_W(DATA_W), .DEFAULT_SEED(DEFAULT_SEED)) u_wr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .load_seed(load_seed),
    .adv(wr_adv), .state(wr_state), .word(wr_word)
  );

  prp_lfsr_gen #(.DATA_W(DATA_W), .DEFAULT_SEED(DEFAULT_SEED)) u_cmp_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .load_seed(load_seed),
    .adv(rd_valid), .state(cmp_state), .word(cmp_word)
  );

  assign wr_inv   = inv_by_row ? wr_row_inv : phase_inv_q;
  assign cmp_inv  = inv_by_row ? rd_row_inv : phase_inv_q;
  assign wr_data  = wr_word ^ {DATA_W{wr_inv}};
  assign expected = cmp_word ^ {DATA_W{cmp_inv}};
  assign cmp_en   = rd_valid & ~load;

  prp_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start), .cmp_en(cmp_en),
    .expected(expected), .rd_data(rd_data),
    .mismatch(mismatch), .err_mask(err_mask)
  );
endmodule

// File: rtl/prp_checker.sv
module prp_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              phase_start,
  input logic              rd_valid,
  input logic              mismatch,
  input logic [DATA_W-1:0] err_mask,
  input logic [31:0]       wr_state,
  input logic [31:0]       cmp_state
);
  assert_mask_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (err_mask == '0));

  assert_mask_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((err_mask & $past(err_mask)) == $past(err_mask)));

  assert_mismatch_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> $past(rd_valid && !start && !phase_start));

  assert_mismatch_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> (err_mask != '0));

  assert_state_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_state != '0) && (cmp_state != '0));

  assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !start && !phase_start) |=> $stable(cmp_state));
endmodule

bind prp_engine prp_checker #(.DATA_W(DATA_W)) u_prp_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .phase_start(phase_start),
  .rd_valid(rd_valid), .mismatch(mismatch), .err_mask(err_mask),
  .wr_state(wr_state), .cmp_state(cmp_state)
);

// File: tb/tb_prp_engine.sv
`timescale 1ns/1ps
module tb_prp_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] DSEED = 32'hACE1_2468;
  localparam logic [31:0] STEP = 32'h9E37_79B9;

  logic clk = 1'b0;
  logic rst_n;
  logic start, phase_start, rep_next, phase_inv, inv_by_row;
  logic wr_adv, wr_row_inv, rd_valid, rd_row_inv;
  logic [31:0] base_seed;
  logic [DW-1:0] rd_data, wr_data, err_mask;
  logic mismatch;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] ms_seed, mw, mc;
  logic mphinv, mmis;
  logic [DW-1:0] mmask;

  always #(CLK_PERIOD/2) clk = ~clk;

  prp_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_start(phase_start),
    .rep_next(rep_next), .base_seed(base_seed), .phase_inv(phase_inv),
    .inv_by_row(inv_by_row), .wr_adv(wr_adv), .wr_row_inv(wr_row_inv),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_row_inv(rd_row_inv),
    .rd_data(rd_data), .mismatch(mismatch), .err_mask(err_mask)
  );

  function automatic logic [31:0] lst(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction
  function automatic logic [DW-1:0] word_of(input logic [31:0] s);
    return {lst(s), s};
  endfunction
  function automatic logic [31:0] fix(input logic [31:0] s);
    return (s == 0) ? DSEED : s;
  endfunction
  function automatic logic [DW-1:0] exp_rd();
    return word_of(mc) ^ {DW{inv_by_row ? rd_row_inv : mphinv}};
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic idle();
    start = 0; phase_start = 0; rep_next = 0; wr_adv = 0; rd_valid = 0;
    wr_row_inv = 0; rd_row_inv = 0; rd_data = '0;
  endtask

  task automatic tick(input string tag);
    logic [DW-1:0] e_wr, e_cmp, diff;
    logic [31:0] sn;
    #1;
    e_wr = word_of(mw) ^ {DW{inv_by_row ? wr_row_inv : mphinv}};
    chk(wr_data, e_wr, tag);
    e_cmp = exp_rd();
    sn = start ? base_seed : (rep_next ? ms_seed + STEP : ms_seed);
    if (start || phase_start) begin
      mw = fix(sn); mc = fix(sn); mphinv = phase_inv; mmis = 0;
      if (start) mmask = '0;
    end else begin
      if (wr_adv) mw = lst(lst(mw));
      if (rd_valid) begin
        diff = rd_data ^ e_cmp; mmis = |diff; mmask |= diff; mc = lst(lst(mc));
      end else mmis = 0;
    end
    ms_seed = sn;
    @(posedge clk); #1;
    chk({63'd0, mismatch}, {63'd0, mmis}, tag);
    chk(err_mask, mmask, tag);
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] w0;
    void'($urandom(32'd4242));
    idle(); phase_inv = 0; inv_by_row = 0; base_seed = '0;
    ms_seed = 0; mw = DSEED; mc = DSEED; mphinv = 0; mmis = 0; mmask = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(err_mask, '0, "R1"); chk({63'd0, mismatch}, '0, "R1");
    chk(wr_data, word_of(DSEED), "R1");

    // R6 zero seed
    base_seed = 0; start = 1; tick("R6");
    chk(wr_data, word_of(DSEED), "R6");
    // R2 start with seed, R3 advances
    base_seed = 32'h1234_5678; start = 1; tick("R2");
    chk(wr_data, word_of(32'h1234_5678), "R2");
    w0 = wr_data;
    repeat (3) begin wr_adv = 1; tick("R3"); end
    // R4 phase reload repeats data
    phase_start = 1; tick("R4");
    chk(wr_data, w0, "R4");
    // R5 repetition step
    rep_next = 1; tick("R5");
    phase_start = 1; tick("R5");
    chk(wr_data, word_of(32'h1234_5678 + STEP), "R5");
    rep_next = 1; phase_start = 1; tick("R5");
    chk(wr_data, word_of(32'h1234_5678 + 2*STEP), "R5");
    // R7 reads with correct data while writes idle
    repeat (4) begin rd_valid = 1; rd_data = exp_rd(); tick("R7"); end
    // R9 single-bit error, R10 sticky
    rd_valid = 1; rd_data = exp_rd() ^ 64'h1; tick("R9");
    rd_valid = 1; rd_data = exp_rd() ^ 64'h8000_0000_0000_0000; tick("R10");
    rd_valid = 1; rd_data = exp_rd(); tick("R9");
    chk(err_mask, 64'h8000_0000_0000_0001, "R10");
    // R11 start wins; read in that cycle not compared
    base_seed = 32'h0BAD_F00D; start = 1; phase_start = 1; rep_next = 1;
    wr_adv = 1; rd_valid = 1; rd_data = ~exp_rd(); tick("R11");
    chk(wr_data, word_of(32'h0BAD_F00D), "R11");
    chk(err_mask, '0, "R10");
    // R8 phase inversion and row inversion
    phase_inv = 1; phase_start = 1; tick("R8");
    chk(wr_data, ~word_of(32'h0BAD_F00D), "R8");
    rd_valid = 1; rd_data = exp_rd(); tick("R8");
    phase_inv = 0; inv_by_row = 1;
    repeat (4) begin
      wr_adv = 1; wr_row_inv = 1; rd_valid = 1; rd_row_inv = 1; rd_data = exp_rd(); tick("R8");
      wr_adv = 1; rd_valid = 1; rd_data = exp_rd(); tick("R8");
    end
    inv_by_row = 0;

    // random traffic
    for (int i = 0; i < 400; i++) begin
      start = ($urandom % 60) == 0;
      phase_start = ($urandom % 25) == 0;
      rep_next = ($urandom % 30) == 0;
      base_seed = (($urandom % 10) == 0) ? 32'd0 : $urandom;
      phase_inv = $urandom % 2;
      if (($urandom % 40) == 0) inv_by_row = ~inv_by_row;
      wr_adv = $urandom % 2; wr_row_inv = $urandom % 2;
      rd_valid = $urandom % 2; rd_row_inv = $urandom % 2;
      rd_data = exp_rd();
      if (($urandom % 8) == 0) rd_data[$urandom % DW] ^= 1'b1;
      tick("R9");
    end
    finish_run();
  end
endmodule